// File: doc/BRIEF.md
# Dual-Mode Parallel Port

An 8-bit parallel port for a small microcontroller-style system. A CPU reaches it over a byte-wide register bus (address, write strobe, write data, read data). On the pin side the port presents a per-bit output value and output enable, and it accepts the level sensed at each pin. Two registers sit on the bus: an output data latch and a direction register. Each has its own address, set by a parameter.

A mode input decides what the pins do. In single-chip mode they are general-purpose I/O. The direction register gates each bit of the latch onto its pin. In expanded multiplexed mode the pins become a shared bus. While the address-phase strobe is high they carry the low address byte. Afterwards they carry data, and the external read/write signal sets the direction. The direction register has no effect in this mode. Pin levels pass through a two-flop synchronizer before the CPU can read them, and the expanded-mode data input is taken from the same point.

Top module: `pio_port`

## Requirements
- R1: In single-chip mode (`mode_exp`=0), `pin_oe[i]` is 1 exactly when direction bit i is 1 (output) and 0 when it is 0 (input).
- R2: A synchronous active-high reset clears the direction register and the output latch. After reset in single-chip mode `pin_oe`=0x00, `pin_out`=0x00, and a read of the direction address returns 0x00.
- R3: A write to the port address stores `bus_wdata` in the output latch whatever the direction bits and the mode are. In single-chip mode `pin_out` shows the latch, so a value written while a bit is an input appears on the pin once that bit becomes an output.
- R4: A read of the port address returns the pin levels from the synchronizer for every bit, including bits set as outputs, and never the latch. A change on `pin_in` becomes visible after the second rising clock edge.
- R5: A read of the direction address returns the stored direction value.
- R6: In expanded mode with `addr_phase`=1, `pin_oe`=0xFF and `pin_out`=`ext_addr_lo`.
- R7: In the expanded data phase (`addr_phase`=0), `ext_rw`=0 (write) gives `pin_oe`=0xFF with `pin_out`=`ext_wdata`. `ext_rw`=1 (read) gives `pin_oe`=0x00 whatever the direction register holds. `ext_rdata` returns the synchronized pin levels.
- R8: When reset is applied with `mode_exp`=1, the pins come out of reset as the multiplexed address/data bus and not as GPIO inputs.
- R9: Register writes take effect on the rising edge that samples `bus_wr`. A read of any other address returns 0x00, and a write there changes neither register.
- R10: On return from expanded to single-chip mode, the pins again follow the direction register and the latch. This includes latch writes made while in expanded mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on address) |
| mode_exp | input | 1 | 0 = single-chip GPIO, 1 = expanded multiplexed bus |
| addr_phase | input | 1 | Expanded mode: 1 = address phase, 0 = data phase |
| ext_rw | input | 1 | Expanded data phase: 1 = read (pins input), 0 = write (pins drive) |
| ext_addr_lo | input | 8 | Low address byte driven in the address phase |
| ext_wdata | input | 8 | Data driven in an expanded write phase |
| ext_rdata | output | 8 | Synchronized pin levels for expanded reads |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |
| pin_in | input | 8 | Per-pin sensed level |

## Verification
The bench drives pin levels that differ from the latch on bits set as outputs. A port that read back the latch instead of the pins fails there, and the bench samples one edge early to catch a synchronizer that is too short. It writes the latch while the pins are inputs, or while the port is in expanded mode, and later turns the pins into outputs. A design that dropped those writes, or drove the pins before the direction changed, shows the wrong `pin_out`. It sets every direction bit to output and then runs an expanded read. A design that let the direction register reach into expanded mode would drive the pins and fight the external device. It also resets while in expanded mode, which catches pins that come up as inputs there.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 8;

    typedef enum logic {
        MODE_SINGLE   = 1'b0,
        MODE_EXPANDED = 1'b1
    } pio_mode_e;

    // Which source feeds the pin drivers this cycle
    typedef enum logic [1:0] {
        SRC_GPIO   = 2'd0,
        SRC_ADDR   = 2'd1,
        SRC_DWRITE = 2'd2,
        SRC_DREAD  = 2'd3
    } pin_src_e;

    function automatic pin_src_e pick_src(pio_mode_e mode, logic aph, logic rw);
        pin_src_e s;
        if (mode == MODE_SINGLE) s = SRC_GPIO;
        else if (aph)            s = SRC_ADDR;
        else if (rw)             s = SRC_DREAD;
        else                     s = SRC_DWRITE;
        return s;
    endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W      = pio_pkg::PORT_W,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs #(
    parameter int W  = pio_pkg::PORT_W,
    parameter int AW = pio_pkg::ADDR_W,
    parameter logic [AW-1:0] PORT_ADDR = 'h03,
    parameter logic [AW-1:0] DIR_ADDR  = 'h07
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  pin_sync,
    output logic [W-1:0]  bus_rdata,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  dir_q
);
    logic hit_port, hit_dir;

    assign hit_port = (bus_addr == PORT_ADDR);
    assign hit_dir  = (bus_addr == DIR_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (bus_wr) begin
            if (hit_port) latch_q <= bus_wdata;
            if (hit_dir)  dir_q   <= bus_wdata;
        end
    end

    // Port reads return pin levels, never the latch
    always_comb begin
        if (hit_port)     bus_rdata = pin_sync;
        else if (hit_dir) bus_rdata = dir_q;
        else              bus_rdata = '0;
    end
endmodule

// File: rtl/pio_pinmux.sv
module pio_pinmux
    import pio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  pio_mode_e    mode,
    input  logic         addr_phase,
    input  logic         ext_rw,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] ext_addr_lo,
    input  logic [W-1:0] ext_wdata,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    pin_src_e src;

    assign src = pick_src(mode, addr_phase, ext_rw);

    always_comb begin
        unique case (src)
            SRC_GPIO: begin
                pin_out = latch_q;
                pin_oe  = dir_q;
            end
            SRC_ADDR: begin
                pin_out = ext_addr_lo;
                pin_oe  = '1;
            end
            SRC_DWRITE: begin
                pin_out = ext_wdata;
                pin_oe  = '1;
            end
            default: begin
                pin_out = ext_wdata;
                pin_oe  = '0;
            end
        endcase
    end
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W,
    parameter logic [AW-1:0] PORT_ADDR = 'h03,
    parameter logic [AW-1:0] DIR_ADDR  = 'h07
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic          mode_exp,
    input  logic          addr_phase,
    input  logic          ext_rw,
    input  logic [W-1:0]  ext_addr_lo,
    input  logic [W-1:0]  ext_wdata,
    output logic [W-1:0]  ext_rdata,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    input  logic [W-1:0]  pin_in
);
    logic [W-1:0] pin_sync;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    pio_mode_e    mode;

    assign mode = mode_exp ? MODE_EXPANDED : MODE_SINGLE;

    pio_sync #(.W(W), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    pio_regs #(.W(W), .AW(AW), .PORT_ADDR(PORT_ADDR), .DIR_ADDR(DIR_ADDR)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .latch_q   (latch_q),
        .dir_q     (dir_q)
    );

    pio_pinmux #(.W(W)) u_mux (
        .mode        (mode),
        .addr_phase  (addr_phase),
        .ext_rw      (ext_rw),
        .latch_q     (latch_q),
        .dir_q       (dir_q),
        .ext_addr_lo (ext_addr_lo),
        .ext_wdata   (ext_wdata),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    assign ext_rdata = pin_sync;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
    parameter int W  = 8,
    parameter int AW = 8,
    parameter logic [AW-1:0] PORT_ADDR = 'h03,
    parameter logic [AW-1:0] DIR_ADDR  = 'h07
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  bus_rdata,
    input logic          mode_exp,
    input logic          addr_phase,
    input logic          ext_rw,
    input logic [W-1:0]  ext_addr_lo,
    input logic [W-1:0]  ext_wdata,
    input logic [W-1:0]  pin_out,
    input logic [W-1:0]  pin_oe
);
    AST_RESET_HIZ: assert property (@(posedge clk)
        $past(rst) && !mode_exp |-> pin_oe == '0 && pin_out == '0);   // R2

    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == DIR_ADDR && !rst) && !mode_exp
        |-> pin_oe == $past(bus_wdata));                               // R1

    AST_ADDR_DRIVE: assert property (@(posedge clk) disable iff (rst)
        mode_exp && addr_phase |-> pin_oe == '1 && pin_out == ext_addr_lo); // R6

    AST_EXP_WRITE: assert property (@(posedge clk) disable iff (rst)
        mode_exp && !addr_phase && !ext_rw |-> pin_oe == '1 && pin_out == ext_wdata); // R7

    AST_EXP_READ_HIZ: assert property (@(posedge clk) disable iff (rst)
        mode_exp && !addr_phase && ext_rw |-> pin_oe == '0);          // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_addr != PORT_ADDR && bus_addr != DIR_ADDR |-> bus_rdata == '0); // R9
endmodule

bind pio_port pio_port_chk #(
    .W(W), .AW(AW), .PORT_ADDR(PORT_ADDR), .DIR_ADDR(DIR_ADDR)
) i_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_exp(mode_exp),
    .addr_phase(addr_phase), .ext_rw(ext_rw), .ext_addr_lo(ext_addr_lo),
    .ext_wdata(ext_wdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_pio_port.sv
module test_pio_port;
    localparam logic [7:0] PA = 8'h03;
    localparam logic [7:0] DA = 8'h07;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       mode_exp = 1'b0;
    logic       addr_phase = 1'b0;
    logic       ext_rw = 1'b1;
    logic [7:0] ext_addr_lo = '0;
    logic [7:0] ext_wdata = '0;
    logic [7:0] ext_rdata;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] pin_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pio_port #(.PORT_ADDR(PA), .DIR_ADDR(DA)) i_pio_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_exp(mode_exp),
        .addr_phase(addr_phase), .ext_rw(ext_rw), .ext_addr_lo(ext_addr_lo),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_in(pin_in)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Inputs change at negedge; results are sampled at the next negedge
    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read_chk(string tag, logic [7:0] a, logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic do_reset(logic exp_mode);
        mode_exp = exp_mode;
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
    endtask

    task automatic t_reset_single();
        do_reset(1'b0);
        check("R2 oe after reset", pin_oe, 8'h00);
        check("R2 out after reset", pin_out, 8'h00);
        bus_read_chk("R2 dir read after reset", DA, 8'h00);
    endtask

    task automatic t_direction();
        bus_addr = DA; bus_wdata = 8'hF0; bus_wr = 1'b1;
        #1;
        check("R9 oe before edge", pin_oe, 8'h00);
        tick();
        bus_wr = 1'b0;
        check("R1 oe follows dir", pin_oe, 8'hF0);
        bus_read_chk("R5 dir readback", DA, 8'hF0);
        bus_write(DA, 8'h00);
        check("R1 all inputs", pin_oe, 8'h00);
    endtask

    task automatic t_latch();
        bus_write(PA, 8'h3C);
        check("R3 hi-z while input", pin_oe, 8'h00);
        bus_write(DA, 8'hFF);
        check("R3 latched value appears", pin_out, 8'h3C);
        check("R1 oe all out", pin_oe, 8'hFF);
    endtask

    task automatic t_readback();
        pin_in = 8'hA5;
        tick();
        bus_read_chk("R4 one edge still old", PA, 8'h00);
        tick();
        bus_read_chk("R4 pin level not latch", PA, 8'hA5);
        pin_in = 8'h0F;
        tick(2);
        bus_read_chk("R4 second pattern", PA, 8'h0F);
    endtask

    task automatic t_unmapped();
        bus_read_chk("R9 unmapped reads zero", 8'h05, 8'h00);
        bus_write(8'h05, 8'h77);
        bus_read_chk("R9 dir untouched", DA, 8'hFF);
        check("R9 latch untouched", pin_out, 8'h3C);
    endtask

    task automatic t_expanded();
        mode_exp = 1'b1; addr_phase = 1'b1; ext_addr_lo = 8'h81;
        #1;
        check("R6 addr oe", pin_oe, 8'hFF);
        check("R6 addr value", pin_out, 8'h81);
        addr_phase = 1'b0; ext_rw = 1'b0; ext_wdata = 8'h42;
        #1;
        check("R7 write oe", pin_oe, 8'hFF);
        check("R7 write value", pin_out, 8'h42);
        ext_rw = 1'b1; pin_in = 8'hC3;
        #1;
        check("R7 read ignores dir", pin_oe, 8'h00);
        tick(2);
        check("R7 ext read data", ext_rdata, 8'hC3);
        bus_write(PA, 8'h99);
        check("R7 still hi-z", pin_oe, 8'h00);
    endtask

    task automatic t_back_to_single();
        tick();
        mode_exp = 1'b0;
        #1;
        check("R10 latch from expanded", pin_out, 8'h99);
        check("R10 dir restored", pin_oe, 8'hFF);
    endtask

    task automatic t_reset_expanded();
        bus_write(DA, 8'hAA);
        addr_phase = 1'b1; ext_addr_lo = 8'h12;
        do_reset(1'b1);
        check("R8 addr drive after reset", pin_oe, 8'hFF);
        check("R8 addr value after reset", pin_out, 8'h12);
        addr_phase = 1'b0; ext_rw = 1'b1;
        #1;
        check("R8 data read hi-z", pin_oe, 8'h00);
        mode_exp = 1'b0;
        #1;
        check("R2 dir cleared by reset", pin_oe, 8'h00);
    endtask

    initial begin
        tick();
        t_reset_single();
        t_direction();
        t_latch();
        t_readback();
        t_unmapped();
        t_expanded();
        t_back_to_single();
        t_reset_expanded();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule